// File: doc/BRIEF.md
# Per-Channel Audio Auto-Mute Detector

This block sits in a multichannel audio path. It watches each channel's stream of signed PCM samples and mutes that channel once it has carried a long, unbroken run of digital silence. Silence means a sample that is either all zeros or all ones, which is -1 in two's complement. A run counts only repeats of the same silence value. A single sample that is not silence releases that channel at once. Every channel keeps its own run counter and its own mute flag.

Each channel's samples come out one register later, with their valid strobe. Any sample that lands while the channel is muted is replaced by zero. A single mute-control pin reports that every channel is muted, and a polarity input sets its active level. The pin's output-enable stays low while reset is held, so an external pad can leave the line floating. Two configuration bits come from a register elsewhere. One is the auto-mute enable (its reset value is 1). The other is the pin polarity (its reset value is 0).

Top module: `automute_top`

## Requirements
- R1: A channel's mute flag rises at the clock edge that accepts the 8192nd consecutive valid silent sample of the same value (parameter RUN_LEN), and not at any earlier edge.
- R2: A silent sample is exactly 24'h000000 or 24'hFFFFFF. Any other valid sample, including 24'h800000 and 24'h7FFFFF, clears the channel's run to zero.
- R3: A valid sample that switches between 24'h000000 and 24'hFFFFFF restarts the run at one. It does not release a mute that is already set.
- R4: One valid non-silent sample on a muted channel clears that channel's mute at the edge that accepts it.
- R5: sampleOutValid for a channel equals its sampleValid delayed by one clock. On that cycle, sampleOut carries the accepted sample, or zero if the channel is muted after that edge. sampleOut holds its value while the strobe is low.
- R6: A cycle with a channel's valid strobe low neither advances nor clears that channel's run, whatever the data.
- R7: Channels are independent. A sample on one channel never changes another channel's run or mute.
- R8: mutePin is active only while every channel is muted. With muteActiveLow = 0 the active level is 1; with muteActiveLow = 1 the active level is 0.
- R9: mutePinOe is 0 while rstN is low and becomes 1 at the first rising clock edge after reset is released. Reset clears every mute flag.
- R10: While amEnable is 0, every mute flag and run counter is cleared at the next clock edge and no channel mutes. When amEnable returns to 1, runs start from zero.
- R11: Once a run reaches RUN_LEN it saturates. Further silent samples keep the channel muted and never wrap the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| amEnable | input | 1 | Auto-mute enable register bit |
| muteActiveLow | input | 1 | Mute pin polarity register bit (1 = active low) |
| sampleIn | input | NUM_CH*SAMPLE_W | Packed signed samples, channel 0 in the low bits |
| sampleValid | input | NUM_CH | Per-channel sample strobe |
| sampleOut | output | NUM_CH*SAMPLE_W | Registered samples, zeroed while muted |
| sampleOutValid | output | NUM_CH | Registered per-channel strobe |
| chanMuted | output | NUM_CH | Per-channel mute flag |
| mutePin | output | 1 | Mute-control pin level |
| mutePinOe | output | 1 | Mute-control pin output enable |

## Verification
The bench drives several kinds of input, and each one separates a different fault.
- Runs of exactly 8191 and 8192 zeros catch an off-by-one in the threshold.
- A 0 run followed by a -1 run shows whether the two silence values are wrongly merged into one count.
- Gaps with the strobe low and non-silent data on the bus reveal counting, or clearing, on invalid cycles.
- The most-negative and most-positive codes show whether silence detection looks at only part of the word.
- Toggling the enable and the polarity separates the clear path from the pin encoding.
- A long random phase mixes rare value flips, rare non-silent samples and gaps in the strobe. It compares every output on every cycle against a reference model in the bench.

// File: rtl/automute_pkg.sv
package automute_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clearRuns;  // wipe all runs and mute flags this cycle
    logic countEn;    // allow runs to advance
  } amStrobes_t;
endpackage

// File: rtl/automute_ctrl.sv
module automute_ctrl
  import automute_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       amEnable,
  input  logic       muteActiveLow,
  input  logic       allMuted,
  output amStrobes_t strobes,
  output logic       mutePin,
  output logic       mutePinOe
);
  logic driveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) driveQ <= 1'b0;
    else       driveQ <= 1'b1;
  end

  always_comb begin
    strobes.clearRuns = !amEnable;
    strobes.countEn   = amEnable;
  end

  assign mutePin   = allMuted ? !muteActiveLow : muteActiveLow;
  assign mutePinOe = driveQ;

  // R9: pin driven from the first edge after reset release
  p_oe_after_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> mutePinOe);
endmodule

// File: rtl/automute_chan.sv
module automute_chan
  import automute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192,
  parameter int CNT_W    = $clog2(RUN_LEN + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  amStrobes_t          strobes,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleOutValid,
  output logic                muted
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0]    cntQ, cntNext;
  logic                lastOnesQ, lastOnesNext;
  logic                muteQ, muteNext;
  logic [SAMPLE_W-1:0] outQ;
  logic                outValidQ;
  logic                isZero, isOnes, isStatic;

  assign isZero   = (sampleIn == '0);
  assign isOnes   = &sampleIn;
  assign isStatic = isZero | isOnes;

  always_comb begin
    cntNext      = cntQ;
    lastOnesNext = lastOnesQ;
    muteNext     = muteQ;
    if (strobes.clearRuns) begin
      cntNext  = '0;
      muteNext = 1'b0;
    end else if (sampleValid && strobes.countEn) begin
      if (isStatic) begin
        if (cntQ != '0 && lastOnesQ == isOnes)
          cntNext = (cntQ == FULL) ? cntQ : cntQ + ONE;
        else
          cntNext = ONE;
        lastOnesNext = isOnes;
        if (cntNext == FULL) muteNext = 1'b1;
      end else begin
        cntNext  = '0;
        muteNext = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      lastOnesQ <= 1'b0;
      muteQ     <= 1'b0;
      outQ      <= '0;
      outValidQ <= 1'b0;
    end else begin
      cntQ      <= cntNext;
      lastOnesQ <= lastOnesNext;
      muteQ     <= muteNext;
      outValidQ <= sampleValid;
      if (sampleValid) outQ <= muteNext ? '0 : sampleIn;
    end
  end

  assign sampleOut      = outQ;
  assign sampleOutValid = outValidQ;
  assign muted          = muteQ;

  // R11: run counter never passes the threshold
  p_cnt_sat_r11: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= FULL);
  // R1: mute only rises with a full run recorded
  p_mute_full_run_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(muteQ) |-> cntQ == FULL);
  // R4: a non-silent accepted sample releases
  p_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && strobes.countEn && !isStatic) |=> !muteQ);
  // R6: idle cycles leave the run alone
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !strobes.clearRuns) |=> ($stable(cntQ) && $stable(muteQ)));
  // R10: disable wipes state next edge
  p_disabled_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearRuns |=> (cntQ == '0 && !muteQ));
  // R5: muted output data is zero
  p_zero_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    (muteQ && outValidQ) |-> outQ == '0);
endmodule

// File: rtl/automute_dp.sv
module automute_dp
  import automute_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  amStrobes_t                 strobes,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleIn,
  input  logic [NUM_CH-1:0]          sampleValid,
  output logic [NUM_CH*SAMPLE_W-1:0] sampleOut,
  output logic [NUM_CH-1:0]          sampleOutValid,
  output logic [NUM_CH-1:0]          chanMuted,
  output logic                       allMuted
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    automute_chan #(
      .SAMPLE_W(SAMPLE_W),
      .RUN_LEN (RUN_LEN),
      .CNT_W   (CNT_W)
    ) u_chan (
      .clk           (clk),
      .rstN          (rstN),
      .strobes       (strobes),
      .sampleIn      (sampleIn[ch*SAMPLE_W +: SAMPLE_W]),
      .sampleValid   (sampleValid[ch]),
      .sampleOut     (sampleOut[ch*SAMPLE_W +: SAMPLE_W]),
      .sampleOutValid(sampleOutValid[ch]),
      .muted         (chanMuted[ch])
    );
  end

  assign allMuted = &chanMuted;

  // R9: reset leaves no channel muted on the first active cycle
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> chanMuted == '0);
endmodule

// File: rtl/automute_top.sv
module automute_top
  import automute_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 8192
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       amEnable,
  input  logic                       muteActiveLow,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleIn,
  input  logic [NUM_CH-1:0]          sampleValid,
  output logic [NUM_CH*SAMPLE_W-1:0] sampleOut,
  output logic [NUM_CH-1:0]          sampleOutValid,
  output logic [NUM_CH-1:0]          chanMuted,
  output logic                       mutePin,
  output logic                       mutePinOe
);
  amStrobes_t strobes;
  logic       allMuted;

  automute_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .amEnable     (amEnable),
    .muteActiveLow(muteActiveLow),
    .allMuted     (allMuted),
    .strobes      (strobes),
    .mutePin      (mutePin),
    .mutePinOe    (mutePinOe)
  );

  automute_dp #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W),
    .RUN_LEN (RUN_LEN)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .sampleIn      (sampleIn),
    .sampleValid   (sampleValid),
    .sampleOut     (sampleOut),
    .sampleOutValid(sampleOutValid),
    .chanMuted     (chanMuted),
    .allMuted      (allMuted)
  );
endmodule

// File: tb/tb_automute_top.sv
`timescale 1ns/1ps
module tb_automute_top;
  localparam int NUM_CH = 8;
  localparam int SW     = 24;
  localparam int RUN    = 8192;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   en = 1'b1;
  logic                   pol = 1'b0;
  logic [NUM_CH*SW-1:0]   sIn = '0;
  logic [NUM_CH-1:0]      vIn = '0;
  logic [NUM_CH*SW-1:0]   sOut;
  logic [NUM_CH-1:0]      sOutV;
  logic [NUM_CH-1:0]      muted;
  logic                   pin, pinOe;

  int tests = 0;
  int fails = 0;

  int              mCnt [NUM_CH];
  bit              mLast[NUM_CH];
  bit              mMute[NUM_CH];
  logic [SW-1:0]   mOut [NUM_CH];
  bit              mOutV[NUM_CH];
  bit              curOnes[NUM_CH];

  always #2.5 clk = ~clk;

  automute_top #(.NUM_CH(NUM_CH), .SAMPLE_W(SW), .RUN_LEN(RUN)) dut (
    .clk(clk), .rstN(rstN), .amEnable(en), .muteActiveLow(pol),
    .sampleIn(sIn), .sampleValid(vIn), .sampleOut(sOut),
    .sampleOutValid(sOutV), .chanMuted(muted), .mutePin(pin), .mutePinOe(pinOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit isSilent(input logic [SW-1:0] v);
    return (v == '0) || (v == '1);
  endfunction

  function automatic bit expPin();
    bit all = 1'b1;
    for (int ch = 0; ch < NUM_CH; ch++) all &= mMute[ch];
    return all ? !pol : pol;
  endfunction

  task automatic modelReset();
    for (int ch = 0; ch < NUM_CH; ch++) begin
      mCnt[ch] = 0; mLast[ch] = 0; mMute[ch] = 0; mOut[ch] = '0; mOutV[ch] = 0;
    end
  endtask

  task automatic step();
    @(posedge clk);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      logic [SW-1:0] s;
      bit ones;
      s = sIn[ch*SW +: SW];
      ones = (s == '1);
      if (!en) begin
        mCnt[ch] = 0; mMute[ch] = 0;
      end else if (vIn[ch]) begin
        if (isSilent(s)) begin
          if (mCnt[ch] != 0 && mLast[ch] == ones)
            mCnt[ch] = (mCnt[ch] < RUN) ? mCnt[ch] + 1 : RUN;
          else
            mCnt[ch] = 1;
          mLast[ch] = ones;
          if (mCnt[ch] == RUN) mMute[ch] = 1;
        end else begin
          mCnt[ch] = 0; mMute[ch] = 0;
        end
      end
      mOutV[ch] = vIn[ch];
      if (vIn[ch]) mOut[ch] = mMute[ch] ? '0 : s;
    end
    @(negedge clk);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      chk(muted[ch] == mMute[ch], "R1", $sformatf("model mute ch%0d", ch), muted[ch], mMute[ch]);
      chk(sOutV[ch] == mOutV[ch], "R5", $sformatf("out valid ch%0d", ch), sOutV[ch], mOutV[ch]);
      chk(sOut[ch*SW +: SW] == mOut[ch], "R5", $sformatf("out data ch%0d", ch),
          sOut[ch*SW +: SW], mOut[ch]);
    end
    chk(pin == expPin(), "R8", "pin level", pin, expPin());
    chk(pinOe == 1'b1, "R9", "pin oe", pinOe, 1);
  endtask

  task automatic setAll(input logic [SW-1:0] v, input bit valid);
    for (int ch = 0; ch < NUM_CH; ch++) sIn[ch*SW +: SW] = v;
    vIn = valid ? '1 : '0;
  endtask

  task automatic runN(input int n);
    repeat (n) step();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    modelReset();
    chk(pinOe == 1'b0, "R9", "oe in reset", pinOe, 0);
    chk(muted == '0, "R9", "mute in reset", muted, 0);
    @(negedge clk);
    chk(pinOe == 1'b0, "R9", "oe held in reset", pinOe, 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(pinOe == 1'b1, "R9", "oe after release", pinOe, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();

    // R1 threshold boundary, all channels zero
    setAll('0, 1);
    runN(RUN - 1);
    chk(muted == '0, "R1", "8191 zeros not muted", muted, 0);
    step();
    chk(muted == '1, "R1", "8192 zeros muted", muted, 8'hFF);
    chk(pin == 1'b1, "R8", "active high pin", pin, 1);
    chk(sOut[SW-1:0] == '0, "R5", "muted sample zero", sOut[SW-1:0], 0);
    runN(20);
    chk(muted == '1, "R11", "saturated still muted", muted, 8'hFF);

    // R4 release on ch2, R7 others untouched
    sIn[2*SW +: SW] = 24'h123456;
    step();
    chk(muted[2] == 1'b0, "R4", "ch2 released", muted[2], 0);
    chk(sOut[2*SW +: SW] == 24'h123456, "R4", "release sample passes", sOut[2*SW +: SW], 24'h123456);
    chk(muted[1] && muted[3], "R7", "neighbours stay muted", muted, 8'hFB);
    chk(pin == 1'b0, "R8", "pin inactive when one unmuted", pin, 0);
    pol = 1'b1;
    step();
    chk(pin == 1'b1, "R8", "inactive level with active-low", pin, 1);

    // R3 value switch restarts run
    setAll('0, 1);
    runN(8000);
    setAll('1, 1);
    runN(RUN - 1);
    chk(muted[2] == 1'b0, "R3", "switch restarts run", muted[2], 0);
    chk(muted[0] == 1'b1, "R3", "switch keeps mute", muted[0], 1);
    step();
    chk(muted == '1, "R3", "full -1 run mutes", muted, 8'hFF);
    chk(pin == 1'b0, "R8", "active low pin", pin, 0);

    // R6 idle cycles with junk data
    setAll(24'h000005, 1);
    step();
    setAll('0, 1);
    runN(8000);
    setAll(24'h000007, 0);
    runN(100);
    setAll('0, 1);
    runN(RUN - 8000 - 1);
    chk(muted == '0, "R6", "idle gap not counted", muted, 0);
    step();
    chk(muted == '1, "R6", "gap bridged run mutes", muted, 8'hFF);

    // R2 extreme codes are not silent
    setAll(24'h800000, 1);
    step();
    chk(muted == '0, "R2", "most negative releases", muted, 0);
    setAll('0, 1);
    runN(5000);
    setAll(24'h7FFFFF, 1);
    step();
    setAll('0, 1);
    runN(RUN - 1);
    chk(muted == '0, "R2", "most positive cleared run", muted, 0);
    step();
    chk(muted == '1, "R2", "clean run mutes", muted, 8'hFF);

    // R10 enable clear
    en = 1'b0;
    step();
    chk(muted == '0, "R10", "disable releases", muted, 0);
    runN(RUN + 100);
    chk(muted == '0, "R10", "no mute while disabled", muted, 0);
    en = 1'b1;
    runN(RUN - 1);
    chk(muted == '0, "R10", "run restarts from zero", muted, 0);
    step();
    chk(muted == '1, "R10", "mutes after re-enable", muted, 8'hFF);

    // Random phase against the model (R1..R8)
    pol = 1'b0;
    for (int ch = 0; ch < NUM_CH; ch++) curOnes[ch] = $urandom % 2;
    for (int i = 0; i < 20000; i++) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        int r;
        r = $urandom % 10000;
        vIn[ch] = ($urandom % 10) != 0;
        if (r < 3) curOnes[ch] = !curOnes[ch];
        if (r == 9999) sIn[ch*SW +: SW] = SW'($urandom % 1000 + 1);
        else sIn[ch*SW +: SW] = curOnes[ch] ? '1 : '0;
      end
      if (i == 15000) pol = 1'b1;
      step();
    end

    doReset();
    chk(muted == '0, "R9", "reset clears mutes", muted, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule